// File: doc/BRIEF.md
# Dual Multi-Mode Timer/Counter

This block holds two identical down-counting timers, X and Y. They share one control byte. Each timer watches one external pin and drives one output pin. The control byte gives each timer a 2-bit function select, one polarity bit and one halt bit.

The four functions are:
- a periodic timer that counts prescaled ticks;
- a square-wave generator that toggles its pin on every underflow;
- an event counter that counts edges on its pin;
- a width meter that counts ticks only while its pin sits at a chosen level.

The polarity bit has a different meaning in each function. It always chooses which synchronized pin edge raises that pin's edge interrupt.

Software reaches the block through a small register port:
- address 0 is the control byte;
- address 1 is timer X's count/reload register;
- address 2 is timer Y's count/reload register.

A counter under zero reloads from its reload latch and raises a one-clock underflow request. The prescaler, the interrupt controller and the pad logic sit outside the block.

Top module: `dual_mode_timer`

## Requirements
- R1: After reset, the control byte, both counters and both reload latches read 0, both output pins are high, and all interrupt requests are low.
- R2: The control byte is written at address 0 and read back there. Bits 1:0 select the function of timer X and bits 5:4 that of timer Y (00 timer, 01 pulse output, 10 event counter, 11 width measurement). Bit 2 is X's polarity bit and bit 6 is Y's. Bit 3 halts X and bit 7 halts Y. A change takes effect from the next clock.
- R3: While a timer's halt bit is 1, its counter does not change, except through a direct write.
- R4: In timer function, a running counter decrements once per cycle with `tick` high. A step taken at zero reloads the latch value instead, and the timer's underflow request is high for exactly the following cycle.
- R5: A write to address 1 or 2 loads both the latch and the counter while that timer is halted. While it runs, the write loads only the latch.
- R6: In pulse output function, a halted timer holds its pin at the inverse of the polarity bit (0 gives high, 1 gives low). A running timer toggles its pin once for each underflow.
- R7: In event counter function, a running counter steps once per synchronized rising pin edge when the polarity bit is 0, and once per falling edge when it is 1. `tick` is ignored.
- R8: In width measurement function, a running counter steps on `tick` only while the synchronized pin is high (polarity 0) or low (polarity 1). Otherwise it holds its value.
- R9: Each pin passes through two flops. A pin edge interrupt pulses for one cycle per synchronized edge: on a falling edge for polarity 0 and on a rising edge for polarity 1, in every function.
- R10: The read port returns the control byte at address 0 and the live counters at addresses 1 and 2. Address 3 reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | 2 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, combinational from the address |
| tick | input | 1 | Prescaled count enable |
| pin_in | input | 2 | External pins, bit 0 for X and bit 1 for Y |
| pin_out | output | 2 | Pulse output pins, bit 0 for X and bit 1 for Y |
| uf_irq | output | 2 | Underflow requests, one per timer |
| pin_irq | output | 2 | Pin edge requests, one per pin |

## Verification
A corrupted counter shows on the read port on the very next cycle it is addressed. It also shifts the next underflow pulse by as many ticks as the error. A lost or doubled pin toggle leaves the output pin inverted until the timer is halted, because every later toggle keeps the wrong phase. A synchronizer or edge detector that is off by one stage moves the edge requests, event counts and width gating by one clock. The cycle-by-cycle comparison catches that at the first pin transition.

// File: rtl/tmr_pkg.sv
package tmr_pkg;

  typedef enum logic [1:0] {
    FN_TIMER = 2'b00,
    FN_PULSE = 2'b01,
    FN_EVENT = 2'b10,
    FN_WIDTH = 2'b11
  } tfunc_e;

  // Whether the counter advances this cycle, for a given function and polarity
  function automatic logic count_step(tfunc_e fn, logic pol, logic tick,
                                      logic rise, logic fall, logic lvl);
    logic s;
    case (fn)
      FN_EVENT: s = pol ? fall : rise;
      FN_WIDTH: s = tick & (lvl == ~pol);
      default:  s = tick;
    endcase
    return s;
  endfunction

  // Edge that raises the pin edge request
  function automatic logic irq_pick(logic pol, logic rise, logic fall);
    return pol ? rise : fall;
  endfunction

endpackage

// File: rtl/pin_edge_sync.sv
module pin_edge_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin,
  output logic lvl,
  output logic rise,
  output logic fall
);
  logic [STAGES-1:0] sh_q;
  logic              prev_q;

  for (genvar k = 0; k < STAGES; k++) begin : g_st
    if (k == 0) begin : g_first
      always_ff @(posedge clk) begin
        if (!rst_n) sh_q[0] <= 1'b0;
        else        sh_q[0] <= pin;
      end
    end else begin : g_next
      always_ff @(posedge clk) begin
        if (!rst_n) sh_q[k] <= 1'b0;
        else        sh_q[k] <= sh_q[k-1];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) prev_q <= 1'b0;
    else        prev_q <= sh_q[STAGES-1];
  end

  assign lvl  = sh_q[STAGES-1];
  assign rise = lvl & ~prev_q;
  assign fall = ~lvl & prev_q;

  // R9: one pulse per synchronized edge
  assert_rise_single_R9: assert property (@(posedge clk) disable iff (!rst_n)
    rise |=> !rise);
  assert_fall_single_R9: assert property (@(posedge clk) disable iff (!rst_n)
    fall |=> !fall);

endmodule

// File: rtl/timer_chan.sv
module timer_chan
  import tmr_pkg::*;
#(
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  tfunc_e        fn,
  input  logic          pol,
  input  logic          halt,
  input  logic          tick,
  input  logic          rise,
  input  logic          fall,
  input  logic          lvl,
  input  logic          wr,
  input  logic [CW-1:0] wdata,
  output logic [CW-1:0] cnt,
  output logic          uf,
  output logic          pout
);
  logic [CW-1:0] cnt_q, lat_q;
  logic          uf_q, pout_q;
  logic          run, under, pulse_run;

  assign run       = !halt && count_step(fn, pol, tick, rise, fall, lvl);
  assign under     = (cnt_q == '0);
  assign pulse_run = (fn == FN_PULSE) && !halt;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      lat_q  <= '0;
      uf_q   <= 1'b0;
      pout_q <= 1'b1;
    end else begin
      if (wr) lat_q <= wdata;
      if (wr && halt)  cnt_q <= wdata;
      else if (run)    cnt_q <= under ? lat_q : cnt_q - 1'b1;
      uf_q <= run && under;
      if (pulse_run) begin
        if (run && under) pout_q <= ~pout_q;
      end else begin
        pout_q <= ~pol;
      end
    end
  end

  assign cnt  = cnt_q;
  assign uf   = uf_q;
  assign pout = pout_q;

  // R3: no step and no write keeps the count
  assert_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!run && !wr) |=> $stable(cnt_q));
  // R4: a step at zero reloads from the latch
  assert_reload_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (run && under && !(wr && halt)) |=> (cnt_q == $past(lat_q)));
  // R4: request follows a step at zero
  assert_uf_src_R4: assert property (@(posedge clk) disable iff (!rst_n)
    uf_q |-> $past(run && under));
  // R6: each underflow in a running pulse timer flips the pin
  assert_toggle_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (pulse_run && run && under) |=> (pout_q != $past(pout_q)));
  // R8: width meter holds while the pin is at the other level
  assert_width_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (fn == FN_WIDTH && lvl == pol && !wr) |=> $stable(cnt_q));

endmodule

// File: rtl/dual_mode_timer.sv
module dual_mode_timer
  import tmr_pkg::*;
#(
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bus_we,
  input  logic [1:0]    bus_addr,
  input  logic [CW-1:0] bus_wdata,
  output logic [CW-1:0] bus_rdata,
  input  logic          tick,
  input  logic [1:0]    pin_in,
  output logic [1:0]    pin_out,
  output logic [1:0]    uf_irq,
  output logic [1:0]    pin_irq
);
  localparam int NCH    = 2;
  localparam int FLD_W  = 4;
  localparam int CTRL_W = NCH * FLD_W;

  logic [CTRL_W-1:0] ctrl_q;
  logic [CW-1:0]     cnt_w [NCH];
  logic [NCH-1:0]    lvl_w, rise_w, fall_w, wr_w;

  always_ff @(posedge clk) begin
    if (!rst_n)                          ctrl_q <= '0;
    else if (bus_we && bus_addr == 2'd0) ctrl_q <= bus_wdata[CTRL_W-1:0];
  end

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    logic pol_w;
    assign pol_w = ctrl_q[FLD_W*i+2];
    assign wr_w[i] = bus_we && (bus_addr == 2'(i + 1));

    pin_edge_sync #(.STAGES(2)) u_sync (
      .clk(clk), .rst_n(rst_n), .pin(pin_in[i]),
      .lvl(lvl_w[i]), .rise(rise_w[i]), .fall(fall_w[i])
    );

    timer_chan #(.CW(CW)) u_chan (
      .clk(clk), .rst_n(rst_n),
      .fn(tfunc_e'(ctrl_q[FLD_W*i +: 2])),
      .pol(pol_w),
      .halt(ctrl_q[FLD_W*i+3]),
      .tick(tick),
      .rise(rise_w[i]), .fall(fall_w[i]), .lvl(lvl_w[i]),
      .wr(wr_w[i]), .wdata(bus_wdata),
      .cnt(cnt_w[i]), .uf(uf_irq[i]), .pout(pin_out[i])
    );

    assign pin_irq[i] = irq_pick(pol_w, rise_w[i], fall_w[i]);
  end

  always_comb begin
    case (bus_addr)
      2'd0:    bus_rdata = CW'(ctrl_q);
      2'd1:    bus_rdata = cnt_w[0];
      2'd2:    bus_rdata = cnt_w[1];
      default: bus_rdata = '0;
    endcase
  end

  // R2: a control write is visible on the next cycle
  assert_ctrl_wr_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && bus_addr == 2'd0) |=> (ctrl_q == $past(bus_wdata[CTRL_W-1:0])));

endmodule

// File: tb/sim_dual_mode_timer.sv
module sim_dual_mode_timer;
  logic       clk = 0;
  logic       rst_n = 0;
  logic       bus_we = 0;
  logic [1:0] bus_addr = 0;
  logic [7:0] bus_wdata = 0;
  logic [7:0] bus_rdata;
  logic       tick = 0;
  logic [1:0] pin_in = 0;
  logic [1:0] pin_out, uf_irq, pin_irq;

  always #4 clk = ~clk;   // 125 MHz

  dual_mode_timer u0 (.*);

  int    checks = 0, fails = 0;
  string cur_req = "R1";

  // behavioural reference
  logic [7:0] m_ctrl;
  logic [1:0] m_s1, m_s2, m_s3, m_out, m_uf;
  int         m_cnt [2];
  int         m_lat [2];

  always @(posedge clk) begin
    if (!rst_n) begin
      m_ctrl = 0; m_s1 = 0; m_s2 = 0; m_s3 = 0; m_out = 2'b11; m_uf = 0;
      for (int i = 0; i < 2; i++) begin m_cnt[i] = 0; m_lat[i] = 0; end
    end else begin
      for (int i = 0; i < 2; i++) begin
        int  f;
        bit  p, h, r, fl, stp, wr;
        f  = (m_ctrl >> (4*i)) & 3;
        p  = m_ctrl[4*i+2];
        h  = m_ctrl[4*i+3];
        r  = m_s2[i] && !m_s3[i];
        fl = !m_s2[i] && m_s3[i];
        if (f == 2)      stp = p ? fl : r;
        else if (f == 3) stp = tick && (m_s2[i] != p);
        else             stp = tick;
        stp = stp && !h;
        wr  = bus_we && bus_addr == i + 1;
        m_uf[i] = stp && m_cnt[i] == 0;
        if (f == 1 && !h) begin
          if (m_uf[i]) m_out[i] = !m_out[i];
        end else m_out[i] = !p;
        if (wr && h) m_cnt[i] = bus_wdata;
        else if (stp) m_cnt[i] = (m_cnt[i] == 0) ? m_lat[i] : m_cnt[i] - 1;
        if (wr) m_lat[i] = bus_wdata;
      end
      if (bus_we && bus_addr == 0) m_ctrl = bus_wdata;
      m_s3 = m_s2; m_s2 = m_s1; m_s1 = pin_in;
    end
  end

  task automatic chk(string req, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic int exp_rdata();
    case (bus_addr)
      2'd0: return m_ctrl;
      2'd1: return m_cnt[0];
      2'd2: return m_cnt[1];
      default: return 0;
    endcase
  endfunction

  function automatic int exp_pirq();
    int v = 0;
    for (int i = 0; i < 2; i++) begin
      bit p = m_ctrl[4*i+2];
      if (p ? (m_s2[i] && !m_s3[i]) : (!m_s2[i] && m_s3[i])) v |= (1 << i);
    end
    return v;
  endfunction

  task automatic compare();
    chk(cur_req, "rdata", bus_rdata, exp_rdata());
    chk(cur_req, "pin_out", pin_out, m_out);
    chk(cur_req, "uf_irq", uf_irq, m_uf);
    chk(cur_req, "pin_irq", pin_irq, exp_pirq());
  endtask

  task automatic wr_reg(int a, int d);
    @(negedge clk); compare();
    bus_we = 1; bus_addr = 2'(a); bus_wdata = 8'(d);
    @(negedge clk); compare();
    bus_we = 0;
  endtask

  task automatic run(int n, int tick_pct, int pin_pct);
    for (int c = 0; c < n; c++) begin
      @(negedge clk); compare();
      bus_addr = 2'(c % 4);
      tick = ($urandom % 100) < tick_pct;
      for (int i = 0; i < 2; i++)
        if (($urandom % 100) < pin_pct) pin_in[i] = ~pin_in[i];
    end
  endtask

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", fails, checks);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    summary();
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    // R1: reset state
    chk("R1", "pin_out", pin_out, 3); chk("R1", "uf_irq", uf_irq, 0);
    chk("R1", "pin_irq", pin_irq, 0); chk("R1", "rdata", bus_rdata, 0);
    rst_n = 1;
    cur_req = "R2"; wr_reg(0, 8'h88);
    @(negedge clk); bus_addr = 0; #1 chk("R2", "ctrl readback", bus_rdata, 8'h88);
    cur_req = "R10"; bus_addr = 3; #1 chk("R10", "addr3", bus_rdata, 0);
    cur_req = "R5";
    wr_reg(1, 5); wr_reg(2, 3);
    bus_addr = 1; #1 chk("R5", "X loaded halted", bus_rdata, 5);
    bus_addr = 2; #1 chk("R5", "Y loaded halted", bus_rdata, 3);
    cur_req = "R4"; wr_reg(0, 8'h00); run(150, 50, 0);
    cur_req = "R5"; wr_reg(1, 7); run(40, 0, 0); run(100, 60, 0);
    cur_req = "R3"; wr_reg(0, 8'h88); run(100, 80, 30);
    cur_req = "R6"; wr_reg(1, 2); wr_reg(2, 4);
    wr_reg(0, 8'h51); run(200, 70, 0);
    wr_reg(0, 8'hD9); run(20, 70, 0);
    wr_reg(0, 8'h15); run(200, 70, 0);
    cur_req = "R7"; wr_reg(0, 8'h62); run(300, 50, 25);
    wr_reg(0, 8'h26); run(300, 50, 25);
    cur_req = "R8"; wr_reg(0, 8'h73); run(300, 60, 5);
    wr_reg(0, 8'h37); run(300, 60, 5);
    cur_req = "R9"; wr_reg(0, 8'h40); run(200, 30, 20);
    wr_reg(0, 8'h04); run(200, 30, 40);
    cur_req = "R10"; run(40, 50, 10);
    summary();
    $finish;
  end
endmodule